// File: doc/BRIEF.md
# Scoreboard Out-of-Order Scheduler

This block is the central hazard tracker for a small out-of-order execution core. It manages five functional units: one integer unit, two multipliers, one adder and one divider. Decoded instructions are offered in program order, each with a unit kind, a destination register and two source registers. The scheduler holds a status entry for each unit and a table that records which unit will produce each register.

Each accepted instruction moves through four phases. At issue the scheduler checks for a free unit and for a write-after-write conflict. In the read phase it waits until both sources are available. In the execute phase the unit runs until it raises its done line. In the write phase the result is held back while an unread operand would be overwritten. Operand values, datapaths and unit latencies are outside the block. The scheduler only grants the issue, operand-read and result-write steps, one pulse per step for each unit.

Unit indices are fixed: 0 integer, 1 multiplier A, 2 multiplier B, 3 adder, 4 divider.

Top module: `sb_scoreboard`

## Requirements
- R1: An instruction offered with `iss_valid_i` high is accepted in the same cycle: `iss_ready_o` goes high and exactly one bit of `iss_gnt_o` is set, naming the lowest-indexed idle unit of the requested kind. The kind codes are 0 integer, 1 multiply, 2 add and 3 divide. At most one instruction is accepted per cycle.
- R2: When every unit of the requested kind is busy, the instruction is not accepted. It is accepted in the first cycle after such a unit's result-write grant.
- R3: When the destination register is already pending from an active instruction, the instruction is not accepted. It is accepted in the cycle after that producer's result-write grant.
- R4: A unit's `rd_gnt_o` bit pulses for exactly one cycle, at the earliest one cycle after issue, and only once neither source is pending from another active unit. Sources that are free at issue give a grant in the cycle after issue.
- R5: `exec_done_i` for a unit takes effect only while that unit is executing, that is, after its operand-read grant. The earliest result-write grant is the cycle after done is sampled. A done pulse while the unit is idle or still waiting to read has no effect.
- R6: A result-write grant frees the unit and clears the pending mark on its destination. Any unit waiting on that result receives its operand-read grant in the next cycle.
- R7: A result write is withheld while another unit that has not yet read its operands holds an available source equal to this destination. It is granted in the cycle after that reader's operand-read grant.
- R8: At most one result-write grant is given per cycle. When several units may write, the lowest unit index wins and the others wait.
- R9: An instruction that depends on nothing outstanding reads, executes and writes while an older instruction is still waiting.
- R10: After reset, all units are idle and no issue, read or write grant is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iss_valid_i | input | 1 | Decoded instruction offered |
| iss_kind_i | input | 2 | Unit kind: 0 integer, 1 multiply, 2 add, 3 divide |
| iss_dst_i | input | REG_W | Destination register |
| iss_src1_i | input | REG_W | First source register |
| iss_src2_i | input | REG_W | Second source register |
| iss_ready_o | output | 1 | Instruction accepted this cycle |
| iss_gnt_o | output | 5 | One-hot unit receiving the instruction |
| rd_gnt_o | output | 5 | Per-unit operand-read grant |
| exec_done_i | input | 5 | Per-unit execution finished |
| wr_gnt_o | output | 5 | One-hot result-write grant |

## Verification
Three instruction streams are run, and every grant is checked against the exact cycle it is due in.

The first stream is three independent multiplies. It shows the second multiply going to the second unit, and the third stalling only until a multiplier frees.

The second stream chains a long divide into an add. An integer op then writes a register that the add has not yet read, and a multiply reuses the add's destination. This stream separates the read-after-write wait, the write-after-read hold and the write-after-write issue stall, and shows the independent integer op running ahead.

The third stream makes two units finish in the same cycle, to check the lowest-index write priority. It also sends stray done pulses to idle and waiting units, which must not shorten any execution.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int unsigned NUM_FU = 5;
  localparam int unsigned FU_W   = $clog2(NUM_FU);

  typedef enum logic [1:0] {
    K_INT = 2'd0,
    K_MUL = 2'd1,
    K_ADD = 2'd2,
    K_DIV = 2'd3
  } fu_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_READ,
    PH_EXEC,
    PH_WRITE
  } phase_e;

  localparam fu_kind_e UNIT_KIND [NUM_FU] = '{K_INT, K_MUL, K_MUL, K_ADD, K_DIV};
endpackage

// File: rtl/sb_prio_pick.sv
module sb_prio_pick #(
  parameter int unsigned N  = 5,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  // lowest index wins: scan downward so the last hit is the lowest
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
        idx_o    = IW'(i);
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/sb_reg_status.sv
module sb_reg_status #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned FU_W     = 3,
  localparam int unsigned REG_W   = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                set_i,
  input  logic [REG_W-1:0]    set_reg_i,
  input  logic [FU_W-1:0]     set_fu_i,
  input  logic                clr_i,
  input  logic [REG_W-1:0]    clr_reg_i,
  output logic [NUM_REGS-1:0] pend_o,
  output logic [FU_W-1:0]     prod_o [NUM_REGS]
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= '0;
      for (int r = 0; r < NUM_REGS; r++) prod_o[r] <= '0;
    end else begin
      if (clr_i) pend_o[clr_reg_i] <= 1'b0;
      if (set_i) begin
        pend_o[set_reg_i] <= 1'b1;
        prod_o[set_reg_i] <= set_fu_i;
      end
    end
  end

  AST_NO_WAW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |-> !pend_o[set_reg_i]); // R3
  AST_CLR_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> pend_o[clr_reg_i]); // R6
endmodule

// File: rtl/sb_fu_entry.sv
module sb_fu_entry
  import sb_pkg::*;
#(
  parameter int unsigned REG_W = 5,
  parameter int unsigned FU_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             iss_i,
  input  logic [REG_W-1:0] dst_i,
  input  logic [REG_W-1:0] src_j_i,
  input  logic [REG_W-1:0] src_k_i,
  input  logic             pend_j_i,
  input  logic             pend_k_i,
  input  logic [FU_W-1:0]  prod_j_i,
  input  logic [FU_W-1:0]  prod_k_i,
  input  logic             wr_any_i,
  input  logic [FU_W-1:0]  wr_idx_i,
  input  logic             done_i,
  input  logic             wr_gnt_i,
  output logic             busy_o,
  output logic             read_o,
  output logic             write_rdy_o,
  output logic [REG_W-1:0] fi_o,
  output logic [REG_W-1:0] fj_o,
  output logic [REG_W-1:0] fk_o,
  output logic             wait_j_o,
  output logic             wait_k_o
);
  phase_e          phase_q;
  logic [FU_W-1:0] qj_q, qk_q;
  logic            rj_q, rk_q;
  logic            rj_iss, rk_iss;

  // a producer writing in the issue cycle counts as already done
  assign rj_iss = !pend_j_i || (wr_any_i && prod_j_i == wr_idx_i);
  assign rk_iss = !pend_k_i || (wr_any_i && prod_k_i == wr_idx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      fi_o    <= '0;
      fj_o    <= '0;
      fk_o    <= '0;
      qj_q    <= '0;
      qk_q    <= '0;
      rj_q    <= 1'b0;
      rk_q    <= 1'b0;
    end else if (iss_i) begin
      phase_q <= PH_READ;
      fi_o    <= dst_i;
      fj_o    <= src_j_i;
      fk_o    <= src_k_i;
      qj_q    <= prod_j_i;
      qk_q    <= prod_k_i;
      rj_q    <= rj_iss;
      rk_q    <= rk_iss;
    end else begin
      unique case (phase_q)
        PH_READ: begin
          if (read_o) begin
            phase_q <= PH_EXEC;
            rj_q    <= 1'b0;
            rk_q    <= 1'b0;
          end else begin
            if (!rj_q && wr_any_i && qj_q == wr_idx_i) rj_q <= 1'b1;
            if (!rk_q && wr_any_i && qk_q == wr_idx_i) rk_q <= 1'b1;
          end
        end
        PH_EXEC:  if (done_i) phase_q <= PH_WRITE;
        PH_WRITE: if (wr_gnt_i) phase_q <= PH_IDLE;
        default: ;
      endcase
    end
  end

  assign busy_o      = (phase_q != PH_IDLE);
  assign read_o      = (phase_q == PH_READ) && rj_q && rk_q;
  assign write_rdy_o = (phase_q == PH_WRITE);
  assign wait_j_o    = (phase_q == PH_READ) && rj_q;
  assign wait_k_o    = (phase_q == PH_READ) && rk_q;

  AST_ISSUE_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_i |-> !busy_o); // R2
  AST_READ_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_o |=> !read_o); // R4
  AST_WRITE_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_gnt_i |=> !busy_o); // R6
endmodule

// File: rtl/sb_scoreboard.sv
module sb_scoreboard
  import sb_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned REG_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iss_valid_i,
  input  logic [1:0]        iss_kind_i,
  input  logic [REG_W-1:0]  iss_dst_i,
  input  logic [REG_W-1:0]  iss_src1_i,
  input  logic [REG_W-1:0]  iss_src2_i,
  output logic              iss_ready_o,
  output logic [NUM_FU-1:0] iss_gnt_o,
  output logic [NUM_FU-1:0] rd_gnt_o,
  input  logic [NUM_FU-1:0] exec_done_i,
  output logic [NUM_FU-1:0] wr_gnt_o
);
  logic [NUM_REGS-1:0] pend;
  logic [FU_W-1:0]     prod [NUM_REGS];

  logic [NUM_FU-1:0] busy, kind_match, iss_req;
  logic [NUM_FU-1:0] wr_rdy, war_blk, wr_req;
  logic [NUM_FU-1:0] wait_j, wait_k;
  logic [REG_W-1:0]  fi [NUM_FU];
  logic [REG_W-1:0]  fj [NUM_FU];
  logic [REG_W-1:0]  fk [NUM_FU];
  logic [FU_W-1:0]   iss_idx, wr_idx;
  logic              wr_any;

  always_comb begin
    for (int u = 0; u < NUM_FU; u++)
      kind_match[u] = (UNIT_KIND[u] == fu_kind_e'(iss_kind_i));
  end

  assign iss_req = kind_match & ~busy & {NUM_FU{iss_valid_i && !pend[iss_dst_i]}};

  sb_prio_pick #(.N(NUM_FU)) u_iss_pick (
    .req_i (iss_req),
    .gnt_o (iss_gnt_o),
    .idx_o (iss_idx),
    .any_o (iss_ready_o)
  );

  // WAR: hold a write while an unread, available operand names its destination
  always_comb begin
    for (int u = 0; u < NUM_FU; u++) begin
      war_blk[u] = 1'b0;
      for (int v = 0; v < NUM_FU; v++) begin
        if (v != u && ((wait_j[v] && fj[v] == fi[u]) || (wait_k[v] && fk[v] == fi[u])))
          war_blk[u] = 1'b1;
      end
    end
  end

  assign wr_req = wr_rdy & ~war_blk;

  sb_prio_pick #(.N(NUM_FU)) u_wr_pick (
    .req_i (wr_req),
    .gnt_o (wr_gnt_o),
    .idx_o (wr_idx),
    .any_o (wr_any)
  );

  sb_reg_status #(.NUM_REGS(NUM_REGS), .FU_W(FU_W)) u_reg_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (iss_ready_o),
    .set_reg_i (iss_dst_i),
    .set_fu_i  (iss_idx),
    .clr_i     (wr_any),
    .clr_reg_i (fi[wr_idx]),
    .pend_o    (pend),
    .prod_o    (prod)
  );

  for (genvar u = 0; u < NUM_FU; u++) begin : g_fu
    sb_fu_entry #(.REG_W(REG_W), .FU_W(FU_W)) u_entry (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .iss_i       (iss_gnt_o[u]),
      .dst_i       (iss_dst_i),
      .src_j_i     (iss_src1_i),
      .src_k_i     (iss_src2_i),
      .pend_j_i    (pend[iss_src1_i]),
      .pend_k_i    (pend[iss_src2_i]),
      .prod_j_i    (prod[iss_src1_i]),
      .prod_k_i    (prod[iss_src2_i]),
      .wr_any_i    (wr_any),
      .wr_idx_i    (wr_idx),
      .done_i      (exec_done_i[u]),
      .wr_gnt_i    (wr_gnt_o[u]),
      .busy_o      (busy[u]),
      .read_o      (rd_gnt_o[u]),
      .write_rdy_o (wr_rdy[u]),
      .fi_o        (fi[u]),
      .fj_o        (fj[u]),
      .fk_o        (fk[u]),
      .wait_j_o    (wait_j[u]),
      .wait_k_o    (wait_k[u])
    );
  end

  AST_ISSUE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(iss_gnt_o)); // R1
  AST_WRITE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_gnt_o)); // R8
endmodule

// File: tb/sb_scoreboard_bench.sv
module sb_scoreboard_bench;
  localparam int NF = 5;
  localparam int RW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          iss_valid;
  logic [1:0]    iss_kind;
  logic [RW-1:0] dst, s1, s2;
  logic          iss_ready;
  logic [NF-1:0] iss_gnt, rd_gnt, wr_gnt, done;
  logic [NF-1:0] done_mdl = '0;
  logic [NF-1:0] stray;

  assign done = done_mdl | stray;

  always #5 clk = ~clk;

  sb_scoreboard #(.NUM_REGS(32)) u_sb_scoreboard (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .iss_valid_i (iss_valid),
    .iss_kind_i  (iss_kind),
    .iss_dst_i   (dst),
    .iss_src1_i  (s1),
    .iss_src2_i  (s2),
    .iss_ready_o (iss_ready),
    .iss_gnt_o   (iss_gnt),
    .rd_gnt_o    (rd_gnt),
    .exec_done_i (done),
    .wr_gnt_o    (wr_gnt)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    checks = 0;
  int    errors = 0;
  bit    finished = 1'b0;
  string cur_req = "R10";
  int    lat [NF];
  int    cnt [NF] = '{default: 0};

  typedef struct {
    int    cyc;
    byte   kind;
    int    unit;
    string req;
  } exp_t;
  exp_t exp_q[$];

  task automatic push(input byte k, input int u, input int c, input string r);
    exp_t e;
    e.cyc = c; e.kind = k; e.unit = u; e.req = r;
    exp_q.push_back(e);
  endtask

  task automatic observe(input byte k, input int u);
    int hit = -1;
    for (int i = 0; i < exp_q.size(); i++)
      if (hit < 0 && exp_q[i].kind == k && exp_q[i].unit == u) hit = i;
    checks++;
    if (hit < 0) begin
      errors++;
      $display("FAIL %s %c grant unit %0d: actual cycle %0d expected none", cur_req, k, u, cyc);
    end else begin
      if (exp_q[hit].cyc != cyc) begin
        errors++;
        $display("FAIL %s %c grant unit %0d: actual cycle %0d expected %0d",
                 exp_q[hit].req, k, u, cyc, exp_q[hit].cyc);
      end
      exp_q.delete(hit);
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // monitor and unit latency model
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      for (int u = 0; u < NF; u++) begin
        if (cnt[u] > 0) begin
          cnt[u]--;
          done_mdl[u] = (cnt[u] == 0);
        end else begin
          done_mdl[u] = 1'b0;
        end
      end
      for (int u = 0; u < NF; u++) if (iss_gnt[u]) observe("I", u);
      for (int u = 0; u < NF; u++) if (rd_gnt[u]) begin
        observe("R", u);
        cnt[u] = lat[u];
      end
      for (int u = 0; u < NF; u++) if (wr_gnt[u]) observe("W", u);
    end
  end

  task automatic do_issue(input logic [1:0] k, input int d, input int a, input int b);
    bit acc = 1'b0;
    iss_kind  = k;
    dst       = d[RW-1:0];
    s1        = a[RW-1:0];
    s2        = b[RW-1:0];
    iss_valid = 1'b1;
    while (!acc) begin
      @(negedge clk);
      acc = iss_ready;
      @(posedge clk);
      #1;
    end
    iss_valid = 1'b0;
  endtask

  task automatic drain();
    int w = 0;
    while (exp_q.size() > 0 && w < 80) begin
      @(posedge clk);
      w++;
    end
    foreach (exp_q[i]) begin
      checks++;
      errors++;
      $display("FAIL %s %c grant unit %0d: actual none expected cycle %0d",
               exp_q[i].req, exp_q[i].kind, exp_q[i].unit, exp_q[i].cyc);
    end
    exp_q.delete();
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int t;
    rst_n = 1'b0; iss_valid = 1'b0; iss_kind = '0;
    dst = '0; s1 = '0; s2 = '0; stray = '0;
    lat = '{1, 3, 3, 2, 6};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(iss_gnt == '0, "R10", "issue grant after reset", int'(iss_gnt), 0);
    chk(rd_gnt == '0, "R10", "read grant after reset", int'(rd_gnt), 0);
    chk(wr_gnt == '0, "R10", "write grant after reset", int'(wr_gnt), 0);
    @(posedge clk);
    #1;

    // three multiplies: unit choice and structural stall
    cur_req = "R1";
    t = cyc;
    push("I", 1, t,      "R1");
    push("I", 2, t + 1,  "R1");
    push("I", 1, t + 6,  "R2");
    push("R", 1, t + 1,  "R4");
    push("R", 2, t + 2,  "R4");
    push("R", 1, t + 7,  "R4");
    push("W", 1, t + 5,  "R6");
    push("W", 2, t + 6,  "R6");
    push("W", 1, t + 11, "R6");
    do_issue(2'd1, 1, 2, 3);
    do_issue(2'd1, 4, 5, 6);
    do_issue(2'd1, 7, 8, 9);
    drain();

    // RAW wait, WAR hold, WAW stall, independent work running ahead
    cur_req = "R7";
    lat = '{1, 3, 3, 2, 6};
    t = cyc;
    push("I", 4, t,      "R1");
    push("I", 3, t + 1,  "R1");
    push("I", 0, t + 2,  "R1");
    push("I", 1, t + 13, "R3");
    push("R", 4, t + 1,  "R4");
    push("R", 0, t + 3,  "R9");
    push("R", 3, t + 9,  "R6");
    push("R", 1, t + 14, "R4");
    push("W", 4, t + 8,  "R6");
    push("W", 0, t + 10, "R7");
    push("W", 3, t + 12, "R4");
    push("W", 1, t + 18, "R3");
    do_issue(2'd3, 0, 1, 2);
    do_issue(2'd2, 6, 0, 8);
    do_issue(2'd0, 8, 9, 10);
    do_issue(2'd1, 6, 1, 1);
    drain();

    // simultaneous completion and stray done pulses
    cur_req = "R5";
    lat = '{4, 3, 3, 3, 6};
    t = cyc;
    push("I", 0, t,      "R1");
    push("I", 3, t + 1,  "R1");
    push("I", 4, t + 2,  "R1");
    push("R", 0, t + 1,  "R4");
    push("R", 3, t + 2,  "R4");
    push("R", 4, t + 3,  "R4");
    push("W", 0, t + 6,  "R8");
    push("W", 3, t + 7,  "R8");
    push("W", 4, t + 10, "R5");
    fork
      begin
        do_issue(2'd0, 1, 2, 3);
        do_issue(2'd2, 4, 5, 6);
        do_issue(2'd3, 7, 8, 9);
      end
      begin
        repeat (2) @(posedge clk);
        #1 stray = 5'b10010;
        repeat (2) @(posedge clk);
        #1 stray = '0;
      end
    join
    drain();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule